// File: doc/BRIEF.md
# SONET Frame Overhead/Payload Timing Generator

This block produces the per-word framing markers for a 32-bit SONET receive path that runs on a 77.76 MHz word clock. It tracks the position of the current word inside a 125 µs frame. A frame has nine rows of 1080 words, so it is 9720 words long. Each row opens with a run of 36 transport-overhead words, and a run of 1044 payload words follows. The block drives a payload flag that is low on overhead words and high on payload words. It also drives a one-cycle frame-start pulse on the first overhead word of every frame, and exports the current row and column. All of these outputs are registered, so they line up with the data word that arrives on the same clock edge.

An upstream framer pulses `resync_i` when it finds a frame boundary. On the next edge the generator jumps to row 0, column 0, and raises the frame-start pulse. After reset the generator waits in a hunting state, with every marker low and the position held at zero, until the first resync arrives. After that it free-runs and wraps at the end of each frame without further help.

The control is a three-state machine. HUNT is the post-reset wait. OVERHEAD covers columns 0 to 35. PAYLOAD covers columns 36 to 1079. Its transitions are:
- HUNT→OVERHEAD on resync.
- OVERHEAD→PAYLOAD on the last overhead column.
- PAYLOAD→OVERHEAD on the last column of a row.
- any state→OVERHEAD on resync.

A column counter and a row counter run beside the state machine.

Top module: `sonet_frame_timer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `frame_start_o`=0, `payload_o`=0, `col_o`=0 and `row_o`=0.
- R2: After reset and before any resync, the block holds `frame_start_o`=0, `payload_o`=0 and position (row 0, column 0) on every cycle.
- R3: When `resync_i` is sampled high at an edge, the outputs after that edge show row 0, column 0, `frame_start_o`=1 and `payload_o`=0. If `resync_i` is held high, this start state is repeated on every edge.
- R4: `payload_o` is 0 on every word whose column is 0 through 35, the overhead run.
- R5: `payload_o` is 1 on every word whose column is 36 through 1079, the payload run.
- R6: After column 1079 of rows 0 to 7, the next word is column 0 of the next row. Without resync the column advances by one per cycle.
- R7: After column 1079 of row 8, the next word is row 0, column 0, with `frame_start_o`=1. A frame therefore repeats every 9720 cycles, and a full frame holds 9396 payload words.
- R8: `frame_start_o` is high only at row 0, column 0. Without resync it lasts exactly one cycle and occurs once per frame.
- R9: A resync in the middle of a frame overrides the running count. The next word is row 0, column 0 with the frame-start pulse, and counting continues from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 77.76 MHz word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resync_i | input | 1 | Frame boundary found upstream; restart at row 0, column 0 on next edge |
| frame_start_o | output | 1 | One-cycle pulse on the first overhead word of a frame |
| payload_o | output | 1 | High on payload words, low on overhead words |
| col_o | output | 11 | Column of the current word within its row (0 to 1079) |
| row_o | output | 4 | Row of the current word within the frame (0 to 8) |

## Verification
A wrong state or column would show within one cycle as a `payload_o` level that disagrees with `col_o`. The cycles around columns 35/36 and 1079/0 are probed directly for this reason. A row counter that wraps at the wrong value, or a broken frame-end condition, only shows at the frame boundary, up to 9720 cycles later. The bench therefore runs across whole frames and counts frame pulses and payload words over a complete frame. Resync is applied in the hunting state, in the middle of a payload run, and held for several cycles, so that a missed override shows on the very next word.

// File: rtl/sft_pkg.sv
package sft_pkg;

    // Phase of the word inside its row.
    typedef enum logic [1:0] {
        ST_HUNT     = 2'd0,
        ST_OVERHEAD = 2'd1,
        ST_PAYLOAD  = 2'd2
    } sft_state_e;

endpackage

// File: rtl/sft_col_counter.sv
module sft_col_counter #(
    parameter int OH_WORDS = 36,
    parameter int PL_WORDS = 1044,
    localparam int ROW_LEN = OH_WORDS + PL_WORDS,
    localparam int COL_W   = $clog2(ROW_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    output logic [COL_W-1:0] col_o,
    output logic             oh_last_o,
    output logic             row_last_o
);

    localparam logic [COL_W-1:0] OH_END  = COL_W'(OH_WORDS - 1);
    localparam logic [COL_W-1:0] ROW_END = COL_W'(ROW_LEN - 1);

    logic [COL_W-1:0] col_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
        end else if (clr_i) begin
            col_q <= '0;
        end else if (en_i) begin
            col_q <= (col_q == ROW_END) ? '0 : col_q + 1'b1;
        end
    end

    assign col_o      = col_q;
    assign oh_last_o  = (col_q == OH_END);
    assign row_last_o = (col_q == ROW_END);

endmodule

// File: rtl/sft_row_counter.sv
module sft_row_counter #(
    parameter int ROWS = 9,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             step_i,
    output logic [ROW_W-1:0] row_o,
    output logic             frame_last_o
);

    localparam logic [ROW_W-1:0] ROW_MAX = ROW_W'(ROWS - 1);

    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (clr_i) begin
            row_q <= '0;
        end else if (step_i) begin
            row_q <= (row_q == ROW_MAX) ? '0 : row_q + 1'b1;
        end
    end

    assign row_o        = row_q;
    assign frame_last_o = (row_q == ROW_MAX);

endmodule

// File: rtl/sft_fsm.sv
module sft_fsm
    import sft_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic resync_i,
    input  logic oh_last_i,
    input  logic row_last_i,
    input  logic frame_last_i,
    output logic running_o,
    output logic payload_o,
    output logic frame_start_o
);

    sft_state_e state_q, state_d;
    logic       sof_q;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:     state_d = resync_i ? ST_OVERHEAD : ST_HUNT;
            ST_OVERHEAD: state_d = (resync_i || !oh_last_i) ? ST_OVERHEAD : ST_PAYLOAD;
            ST_PAYLOAD:  state_d = (resync_i || row_last_i) ? ST_OVERHEAD : ST_PAYLOAD;
            default:     state_d = ST_HUNT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // Output register: start pulse lands with the first overhead word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sof_q <= 1'b0;
        end else begin
            sof_q <= resync_i
                  || ((state_q == ST_PAYLOAD) && row_last_i && frame_last_i);
        end
    end

    assign running_o     = (state_q != ST_HUNT);
    assign payload_o     = (state_q == ST_PAYLOAD);
    assign frame_start_o = sof_q;

endmodule

// File: rtl/sonet_frame_timer.sv
module sonet_frame_timer #(
    parameter int OH_WORDS = 36,
    parameter int PL_WORDS = 1044,
    parameter int ROWS     = 9,
    localparam int ROW_LEN = OH_WORDS + PL_WORDS,
    localparam int COL_W   = $clog2(ROW_LEN),
    localparam int ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             resync_i,
    output logic             frame_start_o,
    output logic             payload_o,
    output logic [COL_W-1:0] col_o,
    output logic [ROW_W-1:0] row_o
);

    logic running;
    logic oh_last;
    logic row_last;
    logic frame_last;

    sft_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .resync_i     (resync_i),
        .oh_last_i    (oh_last),
        .row_last_i   (row_last),
        .frame_last_i (frame_last),
        .running_o    (running),
        .payload_o    (payload_o),
        .frame_start_o(frame_start_o)
    );

    sft_col_counter #(
        .OH_WORDS(OH_WORDS),
        .PL_WORDS(PL_WORDS)
    ) u_col (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (resync_i),
        .en_i      (running),
        .col_o     (col_o),
        .oh_last_o (oh_last),
        .row_last_o(row_last)
    );

    sft_row_counter #(
        .ROWS(ROWS)
    ) u_row (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (resync_i),
        .step_i      (running && row_last),
        .row_o       (row_o),
        .frame_last_o(frame_last)
    );

endmodule

// File: rtl/sft_checker.sv
module sft_checker #(
    parameter int OH_WORDS = 36,
    parameter int PL_WORDS = 1044,
    parameter int ROWS     = 9,
    localparam int ROW_LEN = OH_WORDS + PL_WORDS,
    localparam int COL_W   = $clog2(ROW_LEN),
    localparam int ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             resync_i,
    input logic             frame_start_o,
    input logic             payload_o,
    input logic [COL_W-1:0] col_o,
    input logic [ROW_W-1:0] row_o
);

    localparam logic [COL_W-1:0] C_LAST = COL_W'(ROW_LEN - 1);
    localparam logic [ROW_W-1:0] R_LAST = ROW_W'(ROWS - 1);

    assert_oh_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(col_o) < OH_WORDS) |-> !payload_o);

    assert_pl_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(col_o) >= OH_WORDS) |-> payload_o);

    assert_resync_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        resync_i |=> (frame_start_o && col_o == '0 && row_o == '0));

    assert_row_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!resync_i && col_o == C_LAST && row_o != R_LAST)
        |=> (col_o == '0 && row_o == ROW_W'($past(row_o) + 1'b1)));

    assert_frame_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!resync_i && col_o == C_LAST && row_o == R_LAST)
        |=> (frame_start_o && col_o == '0 && row_o == '0));

    assert_sof_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |-> (col_o == '0 && row_o == '0));

    assert_sof_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_o && !resync_i) |=> !frame_start_o);

endmodule

bind sonet_frame_timer sft_checker #(
    .OH_WORDS(OH_WORDS),
    .PL_WORDS(PL_WORDS),
    .ROWS    (ROWS)
) u_sft_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .resync_i     (resync_i),
    .frame_start_o(frame_start_o),
    .payload_o    (payload_o),
    .col_o        (col_o),
    .row_o        (row_o)
);

// File: tb/sonet_frame_timer_tb.sv
module sonet_frame_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        resync_i = 1'b0;
    logic        frame_start_o;
    logic        payload_o;
    logic [10:0] col_o;
    logic [3:0]  row_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sonet_frame_timer u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .resync_i     (resync_i),
        .frame_start_o(frame_start_o),
        .payload_o    (payload_o),
        .col_o        (col_o),
        .row_o        (row_o)
    );

    // Offsets counted in cycles after the resync edge, with expected outputs
    localparam int NV = 12;
    localparam int V_OFS [NV] = '{0, 1, 35, 36, 37, 1079, 1080, 1115, 1116, 9719, 9720, 9721};
    localparam int V_COL [NV] = '{0, 1, 35, 36, 37, 1079, 0,    35,   36,   1079, 0,    1};
    localparam int V_ROW [NV] = '{0, 0, 0,  0,  0,  0,    1,    1,    1,    8,    0,    0};
    localparam int V_PAY [NV] = '{0, 0, 0,  1,  1,  1,    0,    0,    1,    1,    0,    0};
    localparam int V_SOF [NV] = '{1, 0, 0,  0,  0,  0,    0,    0,    0,    0,    1,    0};
    localparam string V_REQ [NV] = '{"R3", "R4", "R4", "R5", "R5", "R5",
                                    "R6", "R4", "R5", "R7", "R7", "R8"};

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input int c, input int r, input int p, input int s);
        chk(req, "col", int'(col_o), c);
        chk(req, "row", int'(row_o), r);
        chk(req, "payload", int'(payload_o), p);
        chk(req, "frame_start", int'(frame_start_o), s);
    endtask

    task automatic pulse_resync();
        resync_i = 1'b1;
        tick(1);
        resync_i = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int cur;
        int sof_cnt;
        int pay_cnt;
        // R1: reset state
        tick(2);
        chk_all("R1", 0, 0, 0, 0);
        rst_n = 1'b1;
        tick(1);
        chk_all("R1", 0, 0, 0, 0);

        // R2: hunting without resync
        begin
            int bad = 0;
            for (int i = 0; i < 50; i++) begin
                tick(1);
                if (frame_start_o || payload_o || col_o != 0 || row_o != 0) bad++;
            end
            chk("R2", "hunt deviations", bad, 0);
        end

        // Vector table walk from a resync
        pulse_resync();
        cur = 0;
        for (int i = 0; i < NV; i++) begin
            tick(V_OFS[i] - cur);
            cur = V_OFS[i];
            chk_all(V_REQ[i], V_COL[i], V_ROW[i], V_PAY[i], V_SOF[i]);
        end

        // R7/R8: one full frame starting at offset 1 of the frame, counting markers
        sof_cnt = 0;
        pay_cnt = 0;
        for (int i = 0; i < 9720; i++) begin
            tick(1);
            if (frame_start_o) sof_cnt++;
            if (payload_o) pay_cnt++;
        end
        chk("R8", "frame pulses per frame", sof_cnt, 1);
        chk("R7", "payload words per frame", pay_cnt, 9396);

        // R9: mid-frame resync in row 3 payload
        tick(3 * 1080 + 500);
        chk("R9", "payload before resync", int'(payload_o), 1);
        pulse_resync();
        chk_all("R9", 0, 0, 0, 1);
        tick(40);
        chk_all("R9", 40, 0, 1, 0);
        tick(1040);
        chk_all("R6", 0, 1, 0, 0);

        // R3: resync held for three edges keeps restarting
        resync_i = 1'b1;
        tick(1);
        chk_all("R3", 0, 0, 0, 1);
        tick(1);
        chk_all("R3", 0, 0, 0, 1);
        tick(1);
        chk_all("R3", 0, 0, 0, 1);
        resync_i = 1'b0;
        tick(1);
        chk_all("R8", 1, 0, 0, 0);

        // R1/R2: reset mid-run returns to hunting
        tick(200);
        rst_n = 1'b0;
        tick(1);
        chk_all("R1", 0, 0, 0, 0);
        rst_n = 1'b1;
        tick(20);
        chk_all("R2", 0, 0, 0, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule